// File: doc/BRIEF.md
# Multi-Lane Serial Flash Frame Sequencer

This block runs one complete serial flash transaction, a frame, each time it is started. A frame is described by a handful of configuration inputs that are captured at the start: a byte total, a command count that splits the frame into a leading command phase and a trailing data phase, a number of idle clocks placed between the two phases, a two-bit lane mode, a dual/quad width select, a clock divider and the resting level of the serial clock. The block drives the serial clock, an active-low chip select and four data lanes, each split into an output, an output enable and an input.

Command bytes come from a valid/ready byte stream and are shifted out most significant bit first. Whatever the flash returns during them is dropped. Data-phase bytes are clocked with dummy output or with the lanes released. Each received data byte is handed out on a second stream as a one-cycle valid pulse. If the transmit stream is empty when a command byte is due, the serial clock waits. The block shows busy and ready, and it pulses a transmit-done and a receive-done event when the last byte of each phase is complete.

Top module: `flash_frame_seq`

## Requirements
- R1: `ready` is high and `busy` low exactly when no frame is running. A `start` taken while ready with a non-zero byte total makes `busy` high from the next cycle. A `start` with a byte total of 0 is ignored.
- R2: Each serial clock half period lasts max(`cfg_div`,1) system clocks. Between frames, and during the lead and tail half periods, `sclk` rests at `cfg_sclk_hi`. Inside a byte, each bit clock is a low half followed by a high half.
- R3: `cs_n` is high when idle. It falls one half period (the lead) before the first byte-load cycle. It rises one half period (the tail) after the last high half of the final byte.
- R4: Bytes with index below the command count are taken from the transmit stream, one per `tx_valid`/`tx_ready` handshake. They are shifted out most significant bit first, and no `rx_valid` results from them.
- R5: Bytes from the command count up to the total are data bytes. Each returns its received value on `rx_data` with a one-cycle `rx_valid` in the cycle after its last high half. In single-lane data, DQ0 is driven high as dummy output and the input is read from DQ1.
- R6: Lane mode 0 keeps every byte on a single lane. Mode 1 keeps all command bytes single and uses multiple lanes for data. Mode 2 keeps only command byte 0 single and uses multiple lanes for the rest. Mode 3 uses multiple lanes for every byte. Multi-lane data bytes release all lanes (`dq_oe`=0).
- R7: `cfg_quad`=0 selects two lanes, with DQ1 carrying the higher bit of each pair. `cfg_quad`=1 selects four lanes, with DQ3 carrying the highest bit of each nibble. A byte takes 8, 4 or 2 bit clocks for 1, 2 or 4 lanes.
- R8: When the frame has a data phase and `cfg_idle_clks` is non-zero, that many full serial clock periods (low half, then high half) are inserted before the first data byte. During them every lane is released.
- R9: While a command byte is due and `tx_valid` is low, `sclk`, `cs_n` and the lanes hold still (lanes released) and `tx_ready` stays high.
- R10: `tx_done` pulses for one cycle after the last command byte. `rx_done` pulses for one cycle after the last data byte. Each pulses in the cycle after that byte's last high half.
- R11: A command count larger than the byte total is treated as equal to the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame with the present configuration |
| cfg_total_bytes | input | TOTAL_W | Bytes in the frame |
| cfg_cmd_bytes | input | CMD_W | Bytes in the command phase |
| cfg_idle_clks | input | IDLE_W | Idle clocks before the data phase |
| cfg_lane_mode | input | 2 | Which phases use multiple lanes |
| cfg_quad | input | 1 | Multi-lane width: 0 two lanes, 1 four lanes |
| cfg_div | input | DIV_W | System clocks per serial half period |
| cfg_sclk_hi | input | 1 | Serial clock rests high when set |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte accepted this cycle |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | One-cycle pulse with each received byte |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_o | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_i | input | 4 | Lane input values |
| busy | output | 1 | Frame in progress |
| ready | output | 1 | No frame in progress |
| tx_done | output | 1 | Command phase finished pulse |
| rx_done | output | 1 | Data phase finished pulse |

## Verification
A `start` taken at one edge shows as `busy` and low `cs_n` right after that edge. With half period d, the first byte load appears d cycles later. The bit clocks follow in half periods of d cycles, and each data byte's `rx_valid` arrives in the single cycle after its last high half. The bench builds the whole expected cycle sequence of a frame from the configuration before it starts, including lead, stalls, idle clocks and tail. It drives the lane inputs for each cycle from that sequence and compares every output half a clock after each edge. A single-cycle slip in any phase therefore shows on the exact cycle where it occurs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int LANE_MAX = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_LOAD  = 3'd2,
        ST_GAP   = 3'd3,
        ST_LO    = 3'd4,
        ST_HI    = 3'd5,
        ST_TRAIL = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        LW_ONE  = 2'd0,
        LW_TWO  = 2'd1,
        LW_FOUR = 2'd2
    } lane_w_e;

    // lane-mode codes: which phases leave the single lane
    localparam logic [1:0] LM_PLAIN     = 2'd0;
    localparam logic [1:0] LM_DATA_WIDE = 2'd1;
    localparam logic [1:0] LM_OPC_SOLO  = 2'd2;
    localparam logic [1:0] LM_ALL_WIDE  = 2'd3;

    function automatic lane_w_e pick_width(input logic [1:0] mode, input logic quad,
                                           input logic in_cmd, input logic first_byte);
        lane_w_e wide;
        lane_w_e res;
        wide = quad ? LW_FOUR : LW_TWO;
        if (in_cmd) begin
            if (mode == LM_ALL_WIDE)
                res = wide;
            else if (mode == LM_OPC_SOLO && !first_byte)
                res = wide;
            else
                res = LW_ONE;
        end else begin
            res = (mode == LM_PLAIN) ? LW_ONE : wide;
        end
        return res;
    endfunction

    function automatic logic [2:0] lane_count(input lane_w_e w);
        case (w)
            LW_TWO:  return 3'd2;
            LW_FOUR: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [3:0] clocks_per_byte(input lane_w_e w);
        case (w)
            LW_TWO:  return 4'd4;
            LW_FOUR: return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input lane_w_e w);
        case (w)
            LW_TWO:  return 4'b0011;
            LW_FOUR: return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/fs_half_timer.sv
module fs_half_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             expire
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] reload;

    // a divider of zero behaves as one
    always_comb reload = (div == '0) ? '0 : div - 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!run || cnt == '0)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end

    assign expire = run && (cnt == '0);
endmodule

// File: rtl/fs_lane_io.sv
module fs_lane_io
    import flash_seq_pkg::*;
(
    input  lane_w_e    width,
    input  logic       active,
    input  logic       drive,
    input  logic [7:0] tx_sh,
    input  logic [3:0] dq_i,
    output logic [3:0] dq_o,
    output logic [3:0] dq_oe,
    output logic [3:0] rx_bits
);
    logic [2:0] n;
    logic [7:0] aligned;
    logic [3:0] mask;

    always_comb begin
        n       = lane_count(width);
        mask    = lane_mask(width);
        aligned = tx_sh >> (4'd8 - {1'b0, n});
    end

    for (genvar l = 0; l < LANE_MAX; l++) begin : g_lane
        assign dq_oe[l] = active && drive && mask[l];
        assign dq_o[l]  = dq_oe[l] ? aligned[l] : 1'b0;
    end

    assign rx_bits = (width == LW_ONE) ? {3'b000, dq_i[1]} : (dq_i & mask);
endmodule

// File: rtl/flash_frame_seq.sv
module flash_frame_seq
    import flash_seq_pkg::*;
#(
    parameter int TOTAL_W = 32,
    parameter int CMD_W   = 9,
    parameter int IDLE_W  = 4,
    parameter int DIV_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TOTAL_W-1:0] cfg_total_bytes,
    input  logic [CMD_W-1:0]   cfg_cmd_bytes,
    input  logic [IDLE_W-1:0]  cfg_idle_clks,
    input  logic [1:0]         cfg_lane_mode,
    input  logic               cfg_quad,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_sclk_hi,
    input  logic [7:0]         tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    output logic               sclk,
    output logic               cs_n,
    output logic [3:0]         dq_o,
    output logic [3:0]         dq_oe,
    input  logic [3:0]         dq_i,
    output logic               busy,
    output logic               ready,
    output logic               tx_done,
    output logic               rx_done
);
    localparam int CLKCNT_W = 4;

    seq_state_e           state;
    logic [TOTAL_W-1:0]   total_r, cmd_r, byte_idx, cmd_ext;
    logic [IDLE_W-1:0]    idle_r, gap_left;
    logic [1:0]           mode_r;
    logic                 quad_r, cpol_r;
    logic [DIV_W-1:0]     div_r, div_sel;
    logic                 gap_done, gap_hi, cur_cmd;
    lane_w_e              cur_w, load_w;
    logic [CLKCNT_W-1:0]  clk_left;
    logic [7:0]           tx_sh, rx_sh;
    logic                 tmr_run, tmr_exp, in_cmd_now, in_byte, lane_drive;
    logic [2:0]           cur_n;
    logic [3:0]           rx_bits;

    always_comb begin
        cmd_ext    = TOTAL_W'(cfg_cmd_bytes);
        in_cmd_now = byte_idx < cmd_r;
        load_w     = pick_width(mode_r, quad_r, in_cmd_now, byte_idx == '0);
        cur_n      = lane_count(cur_w);
        tmr_run    = state inside {ST_LEAD, ST_GAP, ST_LO, ST_HI, ST_TRAIL};
        div_sel    = (state == ST_IDLE) ? cfg_div : div_r;
        in_byte    = state inside {ST_LO, ST_HI};
        lane_drive = cur_cmd || (cur_w == LW_ONE);
        busy       = state != ST_IDLE;
        ready      = !busy;
        cs_n       = !busy;
        tx_ready   = (state == ST_LOAD) && in_cmd_now;
        case (state)
            ST_IDLE: sclk = cfg_sclk_hi;
            ST_GAP:  sclk = gap_hi;
            ST_LO:   sclk = 1'b0;
            ST_HI:   sclk = 1'b1;
            default: sclk = cpol_r;
        endcase
    end

    fs_half_timer #(.DIV_W(DIV_W)) timer_i (
        .clk(clk), .rst(rst), .run(tmr_run), .div(div_sel), .expire(tmr_exp)
    );

    fs_lane_io lanes_i (
        .width(cur_w), .active(in_byte), .drive(lane_drive), .tx_sh(tx_sh),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .rx_bits(rx_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            total_r  <= '0;
            cmd_r    <= '0;
            byte_idx <= '0;
            idle_r   <= '0;
            gap_left <= '0;
            mode_r   <= LM_PLAIN;
            quad_r   <= 1'b0;
            cpol_r   <= 1'b0;
            div_r    <= '0;
            gap_done <= 1'b0;
            gap_hi   <= 1'b0;
            cur_cmd  <= 1'b0;
            cur_w    <= LW_ONE;
            clk_left <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            tx_done  <= 1'b0;
            rx_done  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_done  <= 1'b0;
            rx_done  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && cfg_total_bytes != '0) begin
                        total_r  <= cfg_total_bytes;
                        cmd_r    <= (cmd_ext > cfg_total_bytes) ? cfg_total_bytes : cmd_ext;
                        idle_r   <= cfg_idle_clks;
                        mode_r   <= cfg_lane_mode;
                        quad_r   <= cfg_quad;
                        div_r    <= cfg_div;
                        cpol_r   <= cfg_sclk_hi;
                        byte_idx <= '0;
                        gap_done <= 1'b0;
                        state    <= ST_LEAD;
                    end
                end
                ST_LEAD: if (tmr_exp) state <= ST_LOAD;
                ST_LOAD: begin
                    rx_sh    <= '0;
                    cur_w    <= load_w;
                    clk_left <= clocks_per_byte(load_w);
                    if (in_cmd_now) begin
                        if (tx_valid) begin
                            tx_sh   <= tx_data;
                            cur_cmd <= 1'b1;
                            state   <= ST_LO;
                        end
                    end else if (idle_r != '0 && !gap_done) begin
                        gap_left <= idle_r;
                        gap_hi   <= 1'b0;
                        gap_done <= 1'b1;
                        state    <= ST_GAP;
                    end else begin
                        tx_sh   <= 8'hFF;
                        cur_cmd <= 1'b0;
                        state   <= ST_LO;
                    end
                end
                ST_GAP: begin
                    if (tmr_exp) begin
                        if (!gap_hi) begin
                            gap_hi <= 1'b1;
                        end else if (gap_left == IDLE_W'(1)) begin
                            state <= ST_LOAD;
                        end else begin
                            gap_left <= gap_left - 1'b1;
                            gap_hi   <= 1'b0;
                        end
                    end
                end
                ST_LO: begin
                    if (tmr_exp) begin
                        rx_sh <= (rx_sh << cur_n) | {4'b0000, rx_bits};
                        state <= ST_HI;
                    end
                end
                ST_HI: begin
                    if (tmr_exp) begin
                        if (clk_left > CLKCNT_W'(1)) begin
                            clk_left <= clk_left - 1'b1;
                            tx_sh    <= tx_sh << cur_n;
                            state    <= ST_LO;
                        end else begin
                            if (!cur_cmd) begin
                                rx_data  <= rx_sh;
                                rx_valid <= 1'b1;
                            end
                            if (cur_cmd && byte_idx == cmd_r - 1'b1)
                                tx_done <= 1'b1;
                            if (!cur_cmd && byte_idx == total_r - 1'b1)
                                rx_done <= 1'b1;
                            byte_idx <= byte_idx + 1'b1;
                            state    <= (byte_idx == total_r - 1'b1) ? ST_TRAIL : ST_LOAD;
                        end
                    end
                end
                ST_TRAIL: if (tmr_exp) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: an accepted start with bytes to send opens a frame
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (start && ready && cfg_total_bytes != '0) |=> busy);

    // R2: inside a frame the clock level moves only on a half-period boundary
    assert_half_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(state) != ST_LOAD && sclk != $past(sclk))
        |-> $past(tmr_exp));

    // R3: chip select never falls together with a clock edge
    assert_cs_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> sclk == $past(sclk));

    // R5: received bytes only surface while a frame is open
    assert_rx_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> busy);

    // R8: lanes are released throughout the idle clocks
    assert_gap_release_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> dq_oe == 4'b0000);

    // R9: a missing transmit byte freezes the bus
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_valid) |=> ($stable(sclk) && $stable(cs_n) && dq_oe == 4'b0000));

    // R10: the two phase-end events never coincide
    assert_done_apart_R10: assert property (@(posedge clk) disable iff (rst)
        !(tx_done && rx_done));
endmodule

// File: tb/flash_frame_seq_tb.sv
`timescale 1ns/1ps
module flash_frame_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cfg_total_bytes = '0;
    logic [8:0]  cfg_cmd_bytes = '0;
    logic [3:0]  cfg_idle_clks = '0;
    logic [1:0]  cfg_lane_mode = '0;
    logic        cfg_quad = 1'b0;
    logic [3:0]  cfg_div = '0;
    logic        cfg_sclk_hi = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid, sclk, cs_n, busy, ready, tx_done, rx_done;
    logic [3:0]  dq_o, dq_oe;
    logic [3:0]  dq_i = '0;

    always #4 clk = ~clk;

    flash_frame_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .cfg_total_bytes(cfg_total_bytes),
        .cfg_cmd_bytes(cfg_cmd_bytes), .cfg_idle_clks(cfg_idle_clks),
        .cfg_lane_mode(cfg_lane_mode), .cfg_quad(cfg_quad), .cfg_div(cfg_div),
        .cfg_sclk_hi(cfg_sclk_hi), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk),
        .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .busy(busy),
        .ready(ready), .tx_done(tx_done), .rx_done(rx_done)
    );

    typedef struct packed {
        logic       sclk, csn, busy, txr, txv, rxv, txd, rxd;
        logic [3:0] oe, dqo, dqi;
        logic [7:0] rxb;
    } rec_t;

    rec_t       exp_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    int         n_checks = 0;
    int         n_errors = 0;
    logic       pend_rxv, pend_txd, pend_rxd;
    logic [7:0] pend_rxb;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    function automatic rec_t blank(input logic lvl);
        rec_t r;
        r = '0;
        r.sclk = lvl;
        r.busy = 1'b1;
        return r;
    endfunction

    task automatic push(input rec_t r);
        r.rxv = pend_rxv;
        r.rxb = pend_rxb;
        r.txd = pend_txd;
        r.rxd = pend_rxd;
        pend_rxv = 1'b0;
        pend_txd = 1'b0;
        pend_rxd = 1'b0;
        exp_q.push_back(r);
    endtask

    function automatic int model_lanes(input int mode, input int quad, input bit is_c, input int idx);
        int multi;
        multi = quad ? 4 : 2;
        if (is_c) begin
            if (mode == 3) return multi;
            if (mode == 2 && idx > 0) return multi;
            return 1;
        end
        return (mode == 0) ? 1 : multi;
    endfunction

    // behavioural reference: the full cycle sequence of one frame
    task automatic build(input int tot, input int cmd, input int idle, input int mode,
                         input int quad, input int div, input logic cpol, input int stall);
        int   d, ce;
        rec_t r;
        exp_q.delete();
        pend_rxv = 0; pend_txd = 0; pend_rxd = 0; pend_rxb = 0;
        d  = (div == 0) ? 1 : div;
        ce = (cmd > tot) ? tot : cmd;
        repeat (d) push(blank(cpol));
        for (int b = 0; b < tot; b++) begin
            bit is_c;
            int n, msk, v, rv;
            is_c = (b < ce);
            n    = model_lanes(mode, quad, is_c, b);
            msk  = (1 << n) - 1;
            r = blank(cpol);
            if (is_c) begin
                r.txr = 1'b1;
                if (b == 0) repeat (stall) push(r);
                r.txv = 1'b1;
            end
            push(r);
            if (!is_c && b == ce && idle > 0) begin
                for (int k = 0; k < idle; k++) begin
                    repeat (d) push(blank(1'b0));
                    repeat (d) push(blank(1'b1));
                end
                push(blank(cpol));
            end
            v  = is_c ? int'(tx_q[b]) : 8'hFF;
            rv = is_c ? 8'h5A : int'(rx_q[b - ce]);
            for (int c = 0; c < 8 / n; c++) begin
                int sh, ob, ib;
                sh = 8 - n * (c + 1);
                ob = (v >> sh) & msk;
                ib = (rv >> sh) & msk;
                r = blank(1'b0);
                r.oe  = is_c ? 4'(msk) : ((n == 1) ? 4'b0001 : 4'b0000);
                r.dqo = is_c ? 4'(ob) : ((n == 1) ? 4'b0001 : 4'b0000);
                r.dqi = (n == 1) ? 4'(ib << 1) : 4'(ib);
                repeat (d) push(r);
                r.sclk = 1'b1;
                repeat (d) push(r);
            end
            if (!is_c) begin pend_rxv = 1'b1; pend_rxb = 8'(rv); end
            if (is_c && b == ce - 1) pend_txd = 1'b1;
            if (!is_c && b == tot - 1) pend_rxd = 1'b1;
        end
        repeat (d) push(blank(cpol));
        r = '0;
        r.sclk = cpol;
        r.csn  = 1'b1;
        repeat (2) push(r);
    endtask

    task automatic run_frame(input string req, input int tot, input int cmd, input int idle,
                             input int mode, input int quad, input int div, input logic cpol,
                             input int stall);
        int  tx_ptr, n_rx, n_tx;
        bit  took;
        build(tot, cmd, idle, mode, quad, div, cpol, stall);
        @(negedge clk);
        cfg_total_bytes = 32'(tot);
        cfg_cmd_bytes   = 9'(cmd);
        cfg_idle_clks   = 4'(idle);
        cfg_lane_mode   = 2'(mode);
        cfg_quad        = quad[0];
        cfg_div         = 4'(div);
        cfg_sclk_hi     = cpol;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tx_ptr = 0; took = 0; n_rx = 0; n_tx = 0;
        foreach (exp_q[i]) begin
            rec_t e;
            e = exp_q[i];
            if (i > 0) @(negedge clk);
            if (took) begin tx_ptr++; n_tx++; end
            check(sclk == e.sclk, "R2", "sclk", sclk, e.sclk);
            check(cs_n == e.csn, "R3", "cs_n", cs_n, e.csn);
            check(busy == e.busy && ready == !e.busy, "R1", "busy", busy, e.busy);
            check(dq_oe == e.oe, "R6", "dq_oe", dq_oe, e.oe);
            check((dq_o & dq_oe) == (e.dqo & e.oe), "R7", "dq_o", dq_o & dq_oe, e.dqo & e.oe);
            check(tx_ready == e.txr, "R9", "tx_ready", tx_ready, e.txr);
            check(rx_valid == e.rxv, "R5", "rx_valid", rx_valid, e.rxv);
            if (e.rxv) check(rx_data == e.rxb, "R5", "rx_data", rx_data, e.rxb);
            if (rx_valid) n_rx++;
            check(tx_done == e.txd, "R10", "tx_done", tx_done, e.txd);
            check(rx_done == e.rxd, "R10", "rx_done", rx_done, e.rxd);
            tx_valid = e.txv;
            tx_data  = (tx_ptr < tx_q.size()) ? tx_q[tx_ptr] : 8'h00;
            dq_i     = e.dqi;
            took     = tx_valid && tx_ready;
        end
        tx_valid = 1'b0;
        dq_i = '0;
        check(n_tx == ((cmd > tot) ? tot : cmd), req, "tx handshakes", n_tx, (cmd > tot) ? tot : cmd);
        check(n_rx == tot - ((cmd > tot) ? tot : cmd), req, "rx bytes", n_rx,
              tot - ((cmd > tot) ? tot : cmd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R1, R3)
        check(ready == 1'b1 && busy == 1'b0, "R1", "reset ready", ready, 1);
        check(cs_n == 1'b1, "R3", "reset cs_n", cs_n, 1);
        check(dq_oe == 4'b0000, "R3", "reset dq_oe", dq_oe, 0);

        // plain SPI: one command byte, two returned bytes (R4, R5)
        tx_q = '{8'hA5}; rx_q = '{8'h3C, 8'hC3};
        run_frame("R4", 3, 1, 0, 0, 0, 2, 1'b0, 0);
        // one byte sent, nothing returned; divider 0 acts as 1 (R4, R2)
        tx_q = '{8'h81}; rx_q = {};
        run_frame("R4", 1, 1, 0, 0, 0, 0, 1'b0, 0);
        // one byte clocked, one returned (R5)
        tx_q = {}; rx_q = '{8'h96};
        run_frame("R5", 1, 0, 0, 0, 0, 1, 1'b0, 0);
        // mode 1 quad, idle clocks, clock resting high (R8, R6, R7)
        tx_q = '{8'h6B, 8'h12}; rx_q = '{8'hE7, 8'h1D};
        run_frame("R8", 4, 2, 2, 1, 1, 1, 1'b1, 0);
        // mode 2 dual: opcode single, address wide (R6, R7)
        tx_q = '{8'hBB, 8'hC4, 8'h2E}; rx_q = '{8'h9F};
        run_frame("R6", 4, 3, 1, 2, 0, 3, 1'b0, 0);
        // mode 3 quad: everything wide (R6)
        tx_q = '{8'hEB}; rx_q = '{8'h47, 8'hB8};
        run_frame("R6", 3, 1, 0, 3, 1, 2, 1'b1, 0);
        // command count above total is clamped (R11)
        tx_q = '{8'h0F, 8'hF0}; rx_q = {};
        run_frame("R11", 2, 20, 0, 0, 0, 1, 1'b0, 0);
        // empty transmit stream stalls the first byte (R9)
        tx_q = '{8'h55}; rx_q = '{8'hAA};
        run_frame("R9", 2, 1, 0, 0, 0, 2, 1'b0, 6);

        // zero-length start is ignored (R1)
        @(negedge clk);
        cfg_total_bytes = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(busy == 1'b0 && cs_n == 1'b1, "R1", "zero-length start", busy, 0);
            @(negedge clk);
        end

        summary();
        $finish;
    end
endmodule